// File: doc/BRIEF.md
# Fixed-Interleave Barrel Thread Selector

This block sits at the front of a fine-grained multithreaded in-order pipeline and decides which hardware thread owns each fetch slot. It keeps one program counter per thread and gives the slots to threads in a fixed rotation: thread 0, then 1, and on up to thread N-1, then back to 0. Every thread therefore gets exactly one slot in every window of N cycles.

Each slot produces three outputs: a fetch PC, the ID of the owning thread and a valid flag. These travel beside the instruction so that later stages can select that thread's copy of architectural state. When the owning thread is not ready, the slot becomes a bubble. No other thread may take it, so the spacing between one thread's instructions never changes. With four threads in a five-stage pipeline, this spacing lets each instruction finish write-back before the next instruction of the same thread reads registers.

Each thread's PC moves forward by a fixed step when that thread issues. A redirect port lets a later stage load a new target into any thread's PC, and the thread fetches from that target at its next slot.

Top module: `barrel_issue_sel`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs clear after that edge (`slot_valid`=0, `slot_thr`=0, `slot_pc`=0) and every thread PC is set to `RESET_VEC`. The first slot after reset belongs to thread 0, and each thread's first slot shows `RESET_VEC`.
- R2: Outputs are registered. After each edge with `rst` low, `slot_thr` equals the previous `slot_thr` plus one modulo `NUM_THR`, and it is always below `NUM_THR`.
- R3: Any `NUM_THR` consecutive slots after reset carry every thread ID exactly once.
- R4: `slot_valid` after an edge equals bit `slot_thr` of `thr_ready` as sampled at that edge. A not-ready owner yields a bubble (`slot_valid`=0) in its own slot.
- R5: A bubble does not advance the owning thread's PC. `slot_pc` shows the thread's current PC on bubbles too, and the thread's next slot repeats that PC.
- R6: A valid slot shows the owning thread's PC and advances that PC by `STEP` bytes for its next slot. The PCs of other threads do not change.
- R7: When `redir_en` is high at an edge, the PC of thread `redir_thr` takes the value `redir_pc`, and that thread's next slot shows it. If the same thread issues at that edge, the issued slot shows the old PC and the redirect overrides the increment.
- R8: Ready bits of threads that do not own the current slot have no effect on the slot outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_ready | input | NUM_THR | Per-thread ready; bit i belongs to thread i |
| redir_en | input | 1 | Load a redirect target this cycle |
| redir_thr | input | TID_W | Thread whose PC is replaced |
| redir_pc | input | PC_W | Redirect target |
| slot_valid | output | 1 | 1 = instruction slot, 0 = bubble |
| slot_thr | output | TID_W | Owning thread of the slot |
| slot_pc | output | PC_W | Fetch PC of the owning thread |

## Verification
Every cycle, the checker confirms the reset state, the step-by-one rotation of the slot ID and its bound, and that the valid flag follows the owner's ready bit from the previous edge. Only the bench scenarios can show the PC history of each thread: that bubbles hold the PC, that a valid issue adds the step, that a redirect lands at the thread's next slot, and that a redirect beats a same-cycle increment. The once-per-window property and the fact that non-owner ready bits are ignored are also shown through those scenarios, by comparing against a per-thread PC model.

// File: rtl/barrel_pkg.sv
package barrel_pkg;
  // Width of a thread ID for a given thread count (at least one bit).
  function automatic int unsigned tid_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/slot_rotor.sv
module slot_rotor #(
  parameter int unsigned NUM_THR = 4,
  parameter int unsigned TID_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [TID_W-1:0] cur_thr
);
  localparam logic [TID_W-1:0] LAST_THR = TID_W'(NUM_THR - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_thr <= '0;
    end else if (cur_thr == LAST_THR) begin
      cur_thr <= '0;
    end else begin
      cur_thr <= cur_thr + 1'b1;
    end
  end
endmodule

// File: rtl/pc_bank.sv
module pc_bank #(
  parameter int unsigned NUM_THR = 4,
  parameter int unsigned TID_W   = 2,
  parameter int unsigned PC_W    = 32,
  parameter logic [PC_W-1:0] RESET_VEC = '0,
  parameter int unsigned STEP    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TID_W-1:0] rd_thr,
  output logic [PC_W-1:0]  rd_pc,
  input  logic             adv,
  input  logic             redir_en,
  input  logic [TID_W-1:0] redir_thr,
  input  logic [PC_W-1:0]  redir_pc
);
  localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

  logic [PC_W-1:0] pc_q [NUM_THR];

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    logic hit_redir;
    logic hit_adv;
    assign hit_redir = redir_en && (redir_thr == TID_W'(g));
    assign hit_adv   = adv && (rd_thr == TID_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        pc_q[g] <= RESET_VEC;
      end else if (hit_redir) begin
        pc_q[g] <= redir_pc;
      end else if (hit_adv) begin
        pc_q[g] <= pc_q[g] + STEP_V;
      end
    end
  end

  assign rd_pc = pc_q[rd_thr];
endmodule

// File: rtl/issue_stage.sv
module issue_stage #(
  parameter int unsigned TID_W = 2,
  parameter int unsigned PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [TID_W-1:0] in_thr,
  input  logic [PC_W-1:0]  in_pc,
  output logic             out_valid,
  output logic [TID_W-1:0] out_thr,
  output logic [PC_W-1:0]  out_pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_thr   <= '0;
      out_pc    <= '0;
    end else begin
      out_valid <= in_valid;
      out_thr   <= in_thr;
      out_pc    <= in_pc;
    end
  end
endmodule

// File: rtl/barrel_issue_sel.sv
module barrel_issue_sel #(
  parameter int unsigned NUM_THR = 4,
  parameter int unsigned PC_W    = 32,
  parameter logic [PC_W-1:0] RESET_VEC = 32'h0000_0100,
  parameter int unsigned STEP    = 4,
  localparam int unsigned TID_W  = barrel_pkg::tid_width(NUM_THR)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_THR-1:0] thr_ready,
  input  logic               redir_en,
  input  logic [TID_W-1:0]   redir_thr,
  input  logic [PC_W-1:0]    redir_pc,
  output logic               slot_valid,
  output logic [TID_W-1:0]   slot_thr,
  output logic [PC_W-1:0]    slot_pc
);
  logic [TID_W-1:0] cur_thr;
  logic [PC_W-1:0]  cur_pc;
  logic             cur_go;

  slot_rotor #(.NUM_THR(NUM_THR), .TID_W(TID_W)) rotor_i (
    .clk     (clk),
    .rst     (rst),
    .cur_thr (cur_thr)
  );

  // The owner alone decides the slot; other threads' ready bits are unused here.
  assign cur_go = thr_ready[cur_thr];

  pc_bank #(
    .NUM_THR(NUM_THR), .TID_W(TID_W), .PC_W(PC_W),
    .RESET_VEC(RESET_VEC), .STEP(STEP)
  ) pcs_i (
    .clk       (clk),
    .rst       (rst),
    .rd_thr    (cur_thr),
    .rd_pc     (cur_pc),
    .adv       (cur_go),
    .redir_en  (redir_en),
    .redir_thr (redir_thr),
    .redir_pc  (redir_pc)
  );

  issue_stage #(.TID_W(TID_W), .PC_W(PC_W)) out_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (cur_go),
    .in_thr    (cur_thr),
    .in_pc     (cur_pc),
    .out_valid (slot_valid),
    .out_thr   (slot_thr),
    .out_pc    (slot_pc)
  );
endmodule

// File: rtl/barrel_issue_sel_chk.sv
module barrel_issue_sel_chk #(
  parameter int unsigned NUM_THR = 4,
  parameter int unsigned TID_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_THR-1:0] thr_ready,
  input logic               slot_valid,
  input logic [TID_W-1:0]   slot_thr
);
  localparam logic [TID_W-1:0] LAST_THR = TID_W'(NUM_THR - 1);

  logic               started;
  logic [NUM_THR-1:0] rdy_q;

  always_ff @(posedge clk) begin
    if (rst) started <= 1'b0;
    else     started <= 1'b1;
    rdy_q <= thr_ready;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!slot_valid && slot_thr == '0));

  assert_rotate_step_R2: assert property (@(posedge clk) disable iff (rst)
    started |=> (slot_thr == (($past(slot_thr) == LAST_THR) ? '0 : $past(slot_thr) + 1'b1)));

  assert_thr_bound_R2: assert property (@(posedge clk) disable iff (rst)
    started |-> (slot_thr <= LAST_THR));

  assert_bubble_owner_R4: assert property (@(posedge clk) disable iff (rst)
    started |-> (slot_valid == rdy_q[slot_thr]));
endmodule

bind barrel_issue_sel barrel_issue_sel_chk #(.NUM_THR(NUM_THR), .TID_W(TID_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .thr_ready  (thr_ready),
  .slot_valid (slot_valid),
  .slot_thr   (slot_thr)
);

// File: tb/barrel_issue_sel_tb_top.sv
module barrel_issue_sel_tb_top;
  localparam int unsigned N    = 4;
  localparam int unsigned PW   = 32;
  localparam logic [31:0] RV   = 32'h0000_0100;
  localparam int unsigned STP  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  thr_ready = '0;
  logic          redir_en = 1'b0;
  logic [1:0]    redir_thr = '0;
  logic [PW-1:0] redir_pc = '0;
  logic          slot_valid;
  logic [1:0]    slot_thr;
  logic [PW-1:0] slot_pc;

  always #2.5 clk = ~clk;

  barrel_issue_sel #(.NUM_THR(N), .PC_W(PW), .RESET_VEC(RV), .STEP(STP)) dut_i (
    .clk(clk), .rst(rst), .thr_ready(thr_ready),
    .redir_en(redir_en), .redir_thr(redir_thr), .redir_pc(redir_pc),
    .slot_valid(slot_valid), .slot_thr(slot_thr), .slot_pc(slot_pc)
  );

  typedef struct {
    logic        v;
    logic [1:0]  t;
    logic [31:0] pc;
    string       vtag;
    string       ptag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;

  logic [31:0] pcm [N];
  string       pc_why [N];
  int          slot_n = 0;
  logic [1:0]  win [N];
  int          win_fill = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the slot it must produce.
  task automatic drive(input logic [N-1:0] rdy, input bit ren, input logic [1:0] rt,
                       input logic [31:0] rp, input string vtag);
    exp_t e;
    int   t;
    @(negedge clk);
    rst = 1'b0;
    thr_ready = rdy; redir_en = ren; redir_thr = rt; redir_pc = rp;
    t = slot_n % N;
    e.t = 2'(t); e.v = rdy[t]; e.pc = pcm[t]; e.vtag = vtag; e.ptag = pc_why[t];
    sb.push_back(e);
    if (rdy[t]) begin pcm[t] = pcm[t] + STP; pc_why[t] = "R6"; end
    else pc_why[t] = "R5";
    if (ren) begin pcm[rt] = rp; pc_why[rt] = "R7"; end
    slot_n++;
  endtask

  // Monitor: compares each produced slot with the queued expectation.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(slot_thr == e.t, "R2", 32'(slot_thr), 32'(e.t));
        check(slot_valid == e.v, e.vtag, 32'(slot_valid), 32'(e.v));
        check(slot_pc == e.pc, e.ptag, slot_pc, e.pc);
        // R3: the last N slot IDs are all distinct
        for (int i = N - 1; i > 0; i--) win[i] = win[i-1];
        win[0] = slot_thr;
        if (win_fill < N) win_fill++;
        if (win_fill == N) begin
          logic [N-1:0] seen;
          seen = '0;
          for (int i = 0; i < N; i++) seen[win[i]] = 1'b1;
          check(seen == '1, "R3", 32'(seen), 32'({N{1'b1}}));
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    for (int i = 0; i < N; i++) begin pcm[i] = RV; pc_why[i] = "R1"; end
    repeat (3) @(posedge clk);
    #1;
    check(slot_valid == 1'b0, "R1", 32'(slot_valid), 32'h0);
    check(slot_thr == 2'd0, "R1", 32'(slot_thr), 32'h0);
    check(slot_pc == 32'h0, "R1", slot_pc, 32'h0);

    // All threads ready: every slot valid, PCs step (R6)
    repeat (12) drive(4'b1111, 1'b0, 2'd0, 32'h0, "R4");
    // Nobody ready: bubbles, PCs held (R4, R5)
    repeat (8) drive(4'b0000, 1'b0, 2'd0, 32'h0, "R4");
    // Only thread 2 ready: others bubble (R4)
    repeat (8) drive(4'b0100, 1'b0, 2'd0, 32'h0, "R4");
    // R8: non-owner ready bits toggled, owner-only bit cleared
    for (int k = 0; k < 8; k++) begin
      int t;
      t = slot_n % N;
      drive(~(4'b0001 << t), 1'b0, 2'd0, 32'h0, "R8");
    end
    // R7: redirect thread 3 while thread 1 owns the slot
    while (slot_n % N != 1) drive(4'b1111, 1'b0, 2'd0, 32'h0, "R4");
    drive(4'b1111, 1'b1, 2'd3, 32'h0000_8000, "R4");
    repeat (4) drive(4'b1111, 1'b0, 2'd0, 32'h0, "R4");
    // R7: redirect the issuing thread in its own slot (redirect wins)
    while (slot_n % N != 2) drive(4'b1111, 1'b0, 2'd0, 32'h0, "R4");
    drive(4'b1111, 1'b1, 2'd2, 32'h0000_A000, "R4");
    repeat (4) drive(4'b1111, 1'b0, 2'd0, 32'h0, "R4");
    // R7: redirect a thread during its bubble
    while (slot_n % N != 0) drive(4'b1111, 1'b0, 2'd0, 32'h0, "R4");
    drive(4'b1110, 1'b1, 2'd0, 32'h0000_C000, "R4");
    repeat (8) drive(4'b1111, 1'b0, 2'd0, 32'h0, "R4");
    // Pseudo-random ready and redirects
    lf = 8'hA5;
    for (int k = 0; k < 60; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      drive(lf[3:0], (lf[7:5] == 3'b101), lf[1:0], {16'h0, lf, 8'h00}, "R4");
    end
    drive(4'b0000, 1'b0, 2'd0, 32'h0, "R4");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule